// File: doc/BRIEF.md
# TDM Cascade Serializer

This block drives one serial line of a time-division multiplexed audio frame that is shared by a chain of identical devices. Each frame-clock period carries one stereo sample pair per device. The device puts its own 64-bit subframe into the first 64 bit slots of the frame. It then forwards the serial stream that arrives on its cascade input from the previous device in the chain, delayed by exactly one subframe, so that the upstream devices fill the later slots. The frame holds up to four devices.

The block runs on the bit clock, which is N × 64 times the frame rate. It samples the frame clock with that bit clock and starts a frame on each low-to-high transition. The sample pair and the word-length setting are captured on the bit-clock edge that sees that transition. Shorter words are left-aligned in their 32-bit slot and zero-padded below. Clock generation, the sample source and the configuration path belong to other blocks.

Top module: `tdm_cascade_ser`

## Requirements
- R1: While `rst_n` is low, and after its release until the first frame-clock rise is sampled, `tdm_out` is 0.
- R2: On the bit-clock edge at which `frame_clk` is sampled high after being sampled low at the previous edge, `tdm_out` takes bit 31 of `left_smp`, which is slot 0. Each later edge advances one slot.
- R3: Slots 0 to 31 carry the left word MSB first (bit 31 down to bit 0). Slots 32 to 63 carry the right word MSB first.
- R4: `wl_sel` picks the word length: 2'b00 = 16 bits, 2'b01 = 24 bits, 2'b10 or 2'b11 = 32 bits. Word bits below that length are sent as 0, so with 16 bits slots 16–31 and 48–63 are 0, and with 24 bits slots 24–31 and 56–63 are 0.
- R5: In slots 64 to N×64−1, `tdm_out` equals `cascade_in` as sampled 63 bit-clock edges before the edge that starts the slot. An upstream device's slot k therefore reappears in slot k+64.
- R6: The device count is N = `dev_sel` + 1 (2'b00 = 1 device up to 2'b11 = 4 devices). After slot N×64−1, `tdm_out` stays 0 until the next frame-clock rise.
- R7: With `dev_sel` = 2'b00, `cascade_in` has no effect: every slot from 64 onward is 0.
- R8: A frame-clock rise always starts a new frame at slot 0, even in the middle of the current frame.
- R9: The samples and the word length are captured at the frame-start edge. Later changes to `left_smp`, `right_smp` or `wl_sel` do not alter the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_clk | input | 1 | Frame clock; a rise starts a frame |
| dev_sel | input | 2 | Devices in the chain minus one |
| wl_sel | input | 2 | Word length: 00 = 16, 01 = 24, 1x = 32 bits |
| left_smp | input | 32 | Left sample, left-aligned |
| right_smp | input | 32 | Right sample, left-aligned |
| cascade_in | input | 1 | Serial stream from the upstream device |
| tdm_out | output | 1 | Serial TDM output, one bit per bit clock |

## Verification
Every result is registered once. The slot value chosen at a bit-clock edge appears at `tdm_out` right after that edge, and the MSB of slot 0 appears at the frame-start edge itself. Forwarded cascade bits come out 63 edges after they are sampled. The bench drives inputs on the falling edge and advances its reference model at the rising edge, using the values it has just driven. It then compares `tdm_out` at the following falling edge, so each prediction is checked in the same bit period in which the design presents it. Frames of nominal, truncated and stretched length are run for all four device counts and all word lengths. Samples are changed in the middle of frames, and random cascade data is applied throughout.

// File: rtl/tdm_casc_pkg.sv
package tdm_casc_pkg;

  localparam int SLOT_W   = 32;
  localparam int SUB_BITS = 2 * SLOT_W;
  localparam int MAX_DEV  = 4;

  typedef enum logic [1:0] {
    SEG_LOCAL = 2'd0,
    SEG_CASC  = 2'd1,
    SEG_IDLE  = 2'd2
  } seg_e;

  // keep the top 16, 24 or all bits of a left-aligned word
  function automatic logic [SLOT_W-1:0] pad_word(input logic [SLOT_W-1:0] w,
                                                 input logic [1:0] wl);
    logic [SLOT_W-1:0] keep;
    case (wl)
      2'b00:   keep = {SLOT_W{1'b1}} << (SLOT_W - 16);
      2'b01:   keep = {SLOT_W{1'b1}} << (SLOT_W - 24);
      default: keep = {SLOT_W{1'b1}};
    endcase
    return w & keep;
  endfunction

endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
  import tdm_casc_pkg::*;
#(
  parameter int SUBF  = SUB_BITS,
  parameter int NDEV  = MAX_DEV,
  parameter int SEL_W = $clog2(NDEV),
  parameter int CNT_W = $clog2(NDEV * SUBF + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_clk,
  input  logic [SEL_W-1:0] dev_sel,
  output logic             frame_rise,
  output logic [CNT_W-1:0] bit_cnt,
  output seg_e             seg
);

  logic             frame_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] frame_len;

  assign frame_rise = frame_clk & ~frame_q;
  assign frame_len  = CNT_W'(dev_sel) * CNT_W'(SUBF) + CNT_W'(SUBF);

  always_comb begin
    if (frame_rise)
      cnt_d = CNT_W'(1);
    else if (bit_cnt < frame_len)
      cnt_d = bit_cnt + CNT_W'(1);
    else
      cnt_d = bit_cnt;
  end

  always_comb begin
    if (bit_cnt < CNT_W'(SUBF))
      seg = SEG_LOCAL;
    else if (bit_cnt < frame_len)
      seg = SEG_CASC;
    else
      seg = SEG_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= 1'b0;
      bit_cnt <= '1;
    end else begin
      frame_q <= frame_clk;
      bit_cnt <= cnt_d;
    end
  end

endmodule

// File: rtl/tdm_local_shifter.sv
module tdm_local_shifter
  import tdm_casc_pkg::*;
#(
  parameter int WORD_W = SLOT_W,
  parameter int SH_W   = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift_en,
  input  logic [1:0]        wl_sel,
  input  logic [WORD_W-1:0] left_smp,
  input  logic [WORD_W-1:0] right_smp,
  output logic              load_bit,
  output logic              cur_bit
);

  logic [SH_W-1:0] subframe;
  logic [SH_W-1:0] sh_q;
  logic [SH_W-1:0] sh_d;

  assign subframe = {pad_word(left_smp, wl_sel), pad_word(right_smp, wl_sel)};
  assign load_bit = subframe[SH_W-1];
  assign cur_bit  = sh_q[SH_W-1];

  always_comb begin
    if (load)
      sh_d = {subframe[SH_W-2:0], 1'b0};
    else if (shift_en)
      sh_d = {sh_q[SH_W-2:0], 1'b0};
    else
      sh_d = sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sh_q <= '0;
    else
      sh_q <= sh_d;
  end

endmodule

// File: rtl/tdm_cascade_delay.sv
module tdm_cascade_delay #(
  parameter int DEPTH = 63
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [DEPTH-1:0] dly_q;
  logic [DEPTH-1:0] dly_d;

  generate
    if (DEPTH == 1) begin : g_one
      assign dly_d = din;
    end else begin : g_many
      assign dly_d = {dly_q[DEPTH-2:0], din};
    end
  endgenerate

  assign dout = dly_q[DEPTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dly_q <= '0;
    else
      dly_q <= dly_d;
  end

endmodule

// File: rtl/tdm_cascade_ser.sv
module tdm_cascade_ser
  import tdm_casc_pkg::*;
#(
  parameter int WORD_W = SLOT_W,
  parameter int NDEV   = MAX_DEV,
  parameter int SUBF   = 2 * WORD_W,
  parameter int SEL_W  = $clog2(NDEV),
  parameter int CNT_W  = $clog2(NDEV * SUBF + 1)
) (
  input  logic              clk_bit,
  input  logic              rst_n,
  input  logic              frame_clk,
  input  logic [SEL_W-1:0]  dev_sel,
  input  logic [1:0]        wl_sel,
  input  logic [WORD_W-1:0] left_smp,
  input  logic [WORD_W-1:0] right_smp,
  input  logic              cascade_in,
  output logic              tdm_out
);

  logic             rst_meta;
  logic             rst_s;
  logic             frame_rise;
  logic [CNT_W-1:0] bit_cnt;
  seg_e             seg;
  logic             shift_en;
  logic             load_bit;
  logic             cur_bit;
  logic             casc_bit;
  logic             out_d;

  // asynchronous assert, two-stage synchronous release
  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  tdm_frame_timer #(.SUBF(SUBF), .NDEV(NDEV), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_timer (
    .clk        (clk_bit),
    .rst_n      (rst_s),
    .frame_clk  (frame_clk),
    .dev_sel    (dev_sel),
    .frame_rise (frame_rise),
    .bit_cnt    (bit_cnt),
    .seg        (seg)
  );

  assign shift_en = !frame_rise && (seg == SEG_LOCAL);

  tdm_local_shifter #(.WORD_W(WORD_W), .SH_W(SUBF)) u_local (
    .clk       (clk_bit),
    .rst_n     (rst_s),
    .load      (frame_rise),
    .shift_en  (shift_en),
    .wl_sel    (wl_sel),
    .left_smp  (left_smp),
    .right_smp (right_smp),
    .load_bit  (load_bit),
    .cur_bit   (cur_bit)
  );

  // one tap short of a subframe: the output register supplies the last stage
  tdm_cascade_delay #(.DEPTH(SUBF - 1)) u_delay (
    .clk   (clk_bit),
    .rst_n (rst_s),
    .din   (cascade_in),
    .dout  (casc_bit)
  );

  always_comb begin
    if (frame_rise)
      out_d = load_bit;
    else begin
      case (seg)
        SEG_LOCAL: out_d = cur_bit;
        SEG_CASC:  out_d = casc_bit;
        default:   out_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_bit or negedge rst_s) begin
    if (!rst_s)
      tdm_out <= 1'b0;
    else
      tdm_out <= out_d;
  end

endmodule

// File: rtl/tdm_cascade_chk.sv
module tdm_cascade_chk #(
  parameter int SUBF  = 64,
  parameter int SEL_W = 2,
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst_s,
  input logic             frame_rise,
  input logic [CNT_W-1:0] bit_cnt,
  input logic [SEL_W-1:0] dev_sel,
  input logic [1:0]       wl_sel,
  input logic             left_msb,
  input logic             cascade_in,
  input logic             tdm_out
);

  logic [SUBF-1:0] c_hist;
  logic [CNT_W-1:0] len_c;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)
      c_hist <= '0;
    else
      c_hist <= {c_hist[SUBF-2:0], cascade_in};
  end

  assign len_c = CNT_W'(dev_sel) * CNT_W'(SUBF) + CNT_W'(SUBF);

  p_msb_first_r2: assert property (@(posedge clk) disable iff (!rst_s)
    frame_rise |=> tdm_out == $past(left_msb));

  p_pad_zero_r4: assert property (@(posedge clk) disable iff (!rst_s)
    (!frame_rise && wl_sel == 2'b00 &&
     ((bit_cnt >= CNT_W'(16) && bit_cnt < CNT_W'(32)) ||
      (bit_cnt >= CNT_W'(48) && bit_cnt < CNT_W'(64)))) |=> !tdm_out);

  p_cascade_fwd_r5: assert property (@(posedge clk) disable iff (!rst_s)
    (!frame_rise && bit_cnt >= CNT_W'(SUBF) && bit_cnt < len_c)
      |=> tdm_out == $past(c_hist[SUBF-2]));

  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (!frame_rise && bit_cnt >= len_c) |=> !tdm_out);

  p_single_dev_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (!frame_rise && dev_sel == '0 && bit_cnt >= CNT_W'(SUBF)) |=> !tdm_out);

endmodule

bind tdm_cascade_ser tdm_cascade_chk #(.SUBF(SUBF), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk_bit),
  .rst_s      (rst_s),
  .frame_rise (frame_rise),
  .bit_cnt    (bit_cnt),
  .dev_sel    (dev_sel),
  .wl_sel     (wl_sel),
  .left_msb   (left_smp[31]),
  .cascade_in (cascade_in),
  .tdm_out    (tdm_out)
);

// File: tb/tdm_cascade_ser_tb.sv
`timescale 1ns/1ps
module tdm_cascade_ser_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_clk;
  logic [1:0]  dev_sel;
  logic [1:0]  wl_sel;
  logic [31:0] left_smp;
  logic [31:0] right_smp;
  logic        cascade_in;
  logic        tdm_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // reference model state
  logic    fc_prev = 1'b0;
  int      pos = 1000;
  int      cur_n = 1;
  int      cur_wl = 2;
  logic [63:0] word;
  logic    hist[$];
  logic    exp_bit;
  string   tag;

  always #10 clk = ~clk;

  tdm_cascade_ser u_dut (
    .clk_bit    (clk),
    .rst_n      (rst_n),
    .frame_clk  (frame_clk),
    .dev_sel    (dev_sel),
    .wl_sel     (wl_sel),
    .left_smp   (left_smp),
    .right_smp  (right_smp),
    .cascade_in (cascade_in),
    .tdm_out    (tdm_out)
  );

  function automatic logic [31:0] keep_bits(input logic [31:0] w, input logic [1:0] wl);
    if (wl == 2'b00) return w & 32'hFFFF_0000;
    if (wl == 2'b01) return w & 32'hFFFF_FF00;
    return w;
  endfunction

  task automatic check(input logic act, input logic expv, input string t);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: tdm_out=%b expected=%b at %0t", t, act, expv, $time);
    end
  endtask

  // one bit period: inputs already driven; model at rising edge, compare at falling edge
  task automatic step(input logic fc);
    frame_clk  = fc;
    cascade_in = 1'($urandom);
    @(posedge clk);
    hist.push_back(cascade_in);
    if (fc && !fc_prev) begin
      tag = (pos < cur_n * 64) ? "R8" : "R2";
      cur_n  = int'(dev_sel) + 1;
      cur_wl = int'(wl_sel);
      word = {keep_bits(left_smp, wl_sel), keep_bits(right_smp, wl_sel)};
      exp_bit = word[63];
      pos = 1;
    end else if (pos < 64) begin
      exp_bit = word[63 - pos];
      tag = (cur_wl < 2 && exp_bit == 1'b0) ? "R4" : "R3,R9";
      pos++;
    end else if (pos < cur_n * 64) begin
      exp_bit = hist[hist.size() - 64];
      tag = "R5";
      pos++;
    end else begin
      exp_bit = 1'b0;
      tag = (cur_n == 1) ? "R7" : "R6";
    end
    fc_prev = fc;
    @(negedge clk);
    check(tdm_out, exp_bit, tag);
  endtask

  task automatic run_frame(input int n, input logic [1:0] wl, input int len,
                           input bit disturb);
    dev_sel   = 2'(n - 1);
    wl_sel    = wl;
    left_smp  = $urandom;
    right_smp = $urandom;
    for (int i = 0; i < len; i++) begin
      if (disturb && i == 1) begin
        // R9: new sample values and word length after capture
        left_smp  = $urandom;
        right_smp = $urandom;
        wl_sel    = 2'b10;
      end
      step(i < len / 2);
      if (disturb && i == 1) wl_sel = wl;
    end
  endtask

  initial begin
    rst_n = 1'b0;
    frame_clk = 1'b0;
    dev_sel = 2'b11;
    wl_sel = 2'b10;
    left_smp = 32'hFFFF_FFFF;
    right_smp = 32'hFFFF_FFFF;
    cascade_in = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(tdm_out, 1'b0, "R1 in reset");
    end
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) step(1'b0); // R1 after release, no frame yet
    // nominal frames for each device count and word length
    for (int n = 1; n <= 4; n++)
      for (int w = 0; w < 3; w++)
        run_frame(n, 2'(w), n * 64, 1'b0);
    run_frame(1, 2'b10, 64 + 40, 1'b0);   // R7 with stretched frame
    run_frame(3, 2'b01, 3 * 64 + 30, 1'b0); // R6 idle tail
    run_frame(4, 2'b10, 100, 1'b0);       // R8 truncated frame
    run_frame(4, 2'b00, 4 * 64, 1'b1);    // R9 mid-frame changes
    run_frame(2, 2'b01, 2 * 64, 1'b1);
    run_frame(2, 2'b11, 2 * 64, 1'b0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule